// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of an Ethernet controller's DMA. Software keeps a ring of 8-byte descriptors in memory. Each descriptor holds a buffer address and an ownership flag. The engine walks that ring, reading one descriptor at a time. It stores each incoming frame, byte by byte, into the buffer that descriptor names. It then rewrites the descriptor's first word with the stored length and a set of per-frame status flags, and moves on to the next descriptor. The descriptor with the wrap flag is the last one in the ring; after it the engine returns to the ring base.

Software hands a descriptor to the engine by setting its empty flag. It tells the engine that descriptors are ready by writing the trigger bit. When the engine reads a descriptor that software still holds, it goes idle. While idle it accepts frames and throws them away, counts each lost frame, and marks the next frame it does store with a miss flag. Each completed frame raises a sticky event that can drive an interrupt line. Framing, CRC computation and address filtering happen upstream. The engine only turns the error indications it receives into descriptor flags.

Top module: `rxbd_engine`

## Requirements
- R1: After reset the engine makes no memory request, `irq` is 0, `drop_cnt` is 0, and `rx_ready` is 1 because the engine is stopped and discards input.
- R2: A register write to index 0 with bit 24 set starts the engine. It reads word 0 of the descriptor at the current pointer, then word 1 at pointer+4. A write to index 0 with bit 24 clear has no effect.
- R3: Descriptor word 0 carries the length in bits 15:0 and the status in bits 31:16; word 1 is the buffer byte address. If status bit 15 (empty) of a fetched descriptor is 0, the engine stops and makes no further memory access until it is triggered again.
- R4: Frame bytes are packed four per 32-bit word, with the first byte in bits 7:0. The words are written at buffer address + 4·k. In a final partial word, the unused byte lanes are written as zero.
- R5: At the end of a frame, descriptor word 0 is rewritten. The length field holds the number of bytes stored. In the status, bit 15 is 0, bit 13 keeps the fetched wrap value, bit 11 is 1, and the flag bits below follow the frame.
- R6: After a descriptor whose status bit 13 was set, the next descriptor is the ring base (register index 1, low 3 bits forced to 0). Otherwise the next descriptor is at the current address + 8. A ring-base write moves the pointer only while the engine is stopped.
- R7: The buffer size is set through register index 2, with bits 3:0 forced to 0. Bytes past the buffer size are accepted but not written, the stored length equals the buffer size, and status bit 0 is set.
- R8: Status bit 5 is set when the frame's total byte count exceeds the 14-bit maximum frame length in bits 29:16 of register index 3.
- R9: Status bit 7 is set when a frame is at least 6 bytes long and its first six bytes are all 0xFF. Status bit 6 is set when bit 0 of the first byte is 1 and bit 7 is not set.
- R10: The error inputs are sampled with the last byte of the frame: `rx_crc_err` sets status bit 2, `rx_align_err` sets bit 4, and `rx_overrun` sets bit 1.
- R11: A frame that arrives while the engine is stopped is taken in whole and discarded, with no memory write. It increments `drop_cnt`, and the next descriptor written back has status bit 8 set; the following ones do not.
- R12: Each write-back sets event bit 25 of register index 4, which stays set until a 1 is written to that bit. `irq` is the event ANDed with bit 25 of mask register index 5.
- R13: A memory request holds its address until `mem_ack`, and `rx_ready` is low while any memory request is pending, so no byte is lost during a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register index |
| reg_wdata | input | 32 | Register write data |
| rx_valid | input | 1 | Frame byte present |
| rx_byte | input | 8 | Frame byte |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_crc_err | input | 1 | CRC error, sampled with the last byte |
| rx_align_err | input | 1 | Non-octet frame, sampled with the last byte |
| rx_overrun | input | 1 | Upstream overrun, sampled with the last byte |
| rx_ready | output | 1 | Byte accepted this cycle when high with rx_valid |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of a 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current request |
| irq | output | 1 | Frame-complete interrupt |
| drop_cnt | output | CNT_W | Count of frames discarded while stopped |

## Verification
The assertions assume a memory responder that acknowledges each request exactly once, and only while the request is held. They also assume that the buffer size and frame-length limit stay unchanged while a frame is being stored, and that the ring base is written only while the engine is stopped. The bench keeps within these assumptions. Its memory model acknowledges every other cycle, its register writes happen between frames, and it programs the ring base before the first trigger. It sweeps every frame length from 1 to well past both the buffer size and the length limit, and it rotates through the whole ring several times.

// File: rtl/rxbd_pkg.sv
package rxbd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC0, ST_DESC1, ST_RECV, ST_DATA, ST_WB, ST_DROP
  } walk_st_t;

  // status bit positions inside the 16-bit descriptor status
  localparam int SB_EMPTY = 15;
  localparam int SB_WRAP  = 13;
  localparam int SB_LAST  = 11;
  localparam int SB_MISS  = 8;
  localparam int SB_BC    = 7;
  localparam int SB_MC    = 6;
  localparam int SB_LG    = 5;
  localparam int SB_NO    = 4;
  localparam int SB_CR    = 2;
  localparam int SB_OV    = 1;
  localparam int SB_TR    = 0;

  localparam int ACT_BIT = 24;
  localparam int EVT_BIT = 25;
  localparam int MFL_LSB = 16;
  localparam int MFL_W   = 14;

  localparam int RG_ACT  = 0;
  localparam int RG_BASE = 1;
  localparam int RG_BSZ  = 2;
  localparam int RG_CTL  = 3;
  localparam int RG_EVT  = 4;
  localparam int RG_MSK  = 5;

  typedef struct packed {
    logic miss;
    logic bc;
    logic mc;
    logic lg;
    logic no;
    logic cr;
    logic ov;
    logic tr;
  } rx_flags_t;

  function automatic logic [15:0] pack_status(logic wrap, rx_flags_t f);
    logic [15:0] s;
    s = '0;
    s[SB_WRAP] = wrap;
    s[SB_LAST] = 1'b1;
    s[SB_MISS] = f.miss;
    s[SB_BC]   = f.bc;
    s[SB_MC]   = f.mc & ~f.bc;
    s[SB_LG]   = f.lg;
    s[SB_NO]   = f.no;
    s[SB_CR]   = f.cr;
    s[SB_OV]   = f.ov;
    s[SB_TR]   = f.tr;
    return s;
  endfunction
endpackage

// File: rtl/rxbd_regs.sv
module rxbd_regs
  import rxbd_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LEN_W   = 16,
  parameter int RA_W    = 3,
  parameter int BSZ_RST = 1536,
  parameter int MFL_RST = 1522
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             evt_set,
  output logic             act_set,
  output logic             base_load,
  output logic [AW-1:0]    ring_base,
  output logic [LEN_W-1:0] buf_size,
  output logic [MFL_W-1:0] max_fl,
  output logic             irq
);
  logic evt_q, msk_q;
  logic wr_act, wr_base, wr_bsz, wr_ctl, wr_evt, wr_msk;
  logic unused_bits;

  assign wr_act  = reg_we && (reg_addr == RA_W'(RG_ACT));
  assign wr_base = reg_we && (reg_addr == RA_W'(RG_BASE));
  assign wr_bsz  = reg_we && (reg_addr == RA_W'(RG_BSZ));
  assign wr_ctl  = reg_we && (reg_addr == RA_W'(RG_CTL));
  assign wr_evt  = reg_we && (reg_addr == RA_W'(RG_EVT));
  assign wr_msk  = reg_we && (reg_addr == RA_W'(RG_MSK));
  assign act_set = wr_act && reg_wdata[ACT_BIT];
  assign unused_bits = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_base <= '0;
      buf_size  <= LEN_W'(BSZ_RST);
      max_fl    <= MFL_W'(MFL_RST);
      base_load <= 1'b0;
      evt_q     <= 1'b0;
      msk_q     <= 1'b0;
      irq       <= 1'b0;
    end else begin
      base_load <= wr_base;
      if (wr_base) ring_base <= reg_wdata[AW-1:0] & ~AW'(7);
      if (wr_bsz)  buf_size  <= {reg_wdata[LEN_W-1:4], 4'b0000};
      if (wr_ctl)  max_fl    <= reg_wdata[MFL_LSB +: MFL_W];
      if (wr_msk)  msk_q     <= reg_wdata[EVT_BIT];
      if (evt_set) evt_q <= 1'b1;
      else if (wr_evt && reg_wdata[EVT_BIT]) evt_q <= 1'b0;
      irq <= evt_q & msk_q;
    end
  end

  // R12: event is sticky until software clears it
  a_r12_event_sticky: assert property (@(posedge clk) disable iff (rst)
    (evt_q && !wr_evt) |=> evt_q);
endmodule

// File: rtl/rxbd_pack.sv
module rxbd_pack #(
  parameter int LANES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               push,
  input  logic [7:0]         din,
  output logic [8*LANES-1:0] word,
  output logic               last_lane
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  logic [LW-1:0] lane_q;

  assign last_lane = (lane_q == LW'(LANES-1));

  always_ff @(posedge clk) begin
    if (rst || clr) lane_q <= '0;
    else if (push) lane_q <= last_lane ? '0 : lane_q + LW'(1);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (rst || clr) b_q <= 8'h00;
      else if (push && lane_q == LW'(g)) b_q <= din;
    end
    assign word[8*g +: 8] = b_q;
  end
endmodule

// File: rtl/rxbd_walker.sv
module rxbd_walker
  import rxbd_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_set,
  input  logic             base_load,
  input  logic [AW-1:0]    ring_base,
  input  logic [LEN_W-1:0] buf_size,
  input  logic [MFL_W-1:0] max_fl,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_eof,
  input  logic             rx_crc_err,
  input  logic             rx_align_err,
  input  logic             rx_overrun,
  output logic             rx_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             evt_set,
  output logic [CNT_W-1:0] drop_cnt
);
  localparam int LANES = 4;

  walk_st_t      state;
  logic          active;
  logic [AW-1:0] cur_ptr, buf_wr;
  logic          wrap_q, eof_q;
  logic [LEN_W-1:0] scnt, fcnt;
  rx_flags_t     flg;
  logic          fire, store, need_wr, last_lane, pk_clr;
  logic [31:0]   pk_word;
  logic [15:0]   status;

  assign rx_ready = (state == ST_RECV) || (state == ST_DROP) ||
                    (state == ST_IDLE && !active);
  assign fire     = rx_valid && rx_ready;
  assign store    = (scnt < buf_size);
  assign need_wr  = store && (last_lane || rx_eof);
  assign pk_clr   = mem_ack && (state == ST_DATA || state == ST_DESC1);

  assign mem_req  = (state == ST_DESC0) || (state == ST_DESC1) ||
                    (state == ST_DATA)  || (state == ST_WB);
  assign mem_we   = (state == ST_DATA) || (state == ST_WB);
  assign status   = pack_status(wrap_q, flg);
  assign evt_set  = (state == ST_WB) && mem_ack;

  always_comb begin
    case (state)
      ST_DESC1: mem_addr = cur_ptr + AW'(4);
      ST_DATA:  mem_addr = buf_wr;
      default:  mem_addr = cur_ptr;
    endcase
    mem_wdata = (state == ST_WB) ? {status, 16'(scnt)} : pk_word;
  end

  rxbd_pack #(.LANES(LANES)) u_pack (
    .clk(clk), .rst(rst), .clr(pk_clr),
    .push(fire && state == ST_RECV && store), .din(rx_byte),
    .word(pk_word), .last_lane(last_lane)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      active   <= 1'b0;
      cur_ptr  <= '0;
      buf_wr   <= '0;
      wrap_q   <= 1'b0;
      eof_q    <= 1'b0;
      scnt     <= '0;
      fcnt     <= '0;
      flg      <= '0;
      drop_cnt <= '0;
    end else begin
      if (act_set) active <= 1'b1;
      if (base_load && !active) cur_ptr <= ring_base;
      case (state)
        ST_IDLE: begin
          if (active) state <= ST_DESC0;
          else if (fire) begin
            if (rx_eof) begin
              drop_cnt <= drop_cnt + CNT_W'(1);
              flg.miss <= 1'b1;
            end else state <= ST_DROP;
          end
        end
        ST_DROP: begin
          if (fire && rx_eof) begin
            drop_cnt <= drop_cnt + CNT_W'(1);
            flg.miss <= 1'b1;
            state    <= ST_IDLE;
          end
        end
        ST_DESC0: begin
          if (mem_ack) begin
            if (mem_rdata[16+SB_EMPTY]) begin
              wrap_q <= mem_rdata[16+SB_WRAP];
              state  <= ST_DESC1;
            end else begin
              if (!act_set) active <= 1'b0;
              state <= ST_IDLE;
            end
          end
        end
        ST_DESC1: begin
          if (mem_ack) begin
            buf_wr <= mem_rdata[AW-1:0];
            scnt   <= '0;
            fcnt   <= '0;
            eof_q  <= 1'b0;
            flg    <= '{miss: flg.miss, bc: 1'b1, default: 1'b0};
            state  <= ST_RECV;
          end
        end
        ST_RECV: begin
          if (fire) begin
            if (fcnt == '0) flg.mc <= rx_byte[0];
            if (fcnt < LEN_W'(6) && rx_byte != 8'hFF) flg.bc <= 1'b0;
            if (fcnt != '1) fcnt <= fcnt + LEN_W'(1);
            if (store) scnt <= scnt + LEN_W'(1);
            else flg.tr <= 1'b1;
            if (rx_eof) begin
              flg.lg <= (fcnt >= LEN_W'(max_fl));
              flg.no <= rx_align_err;
              flg.cr <= rx_crc_err;
              flg.ov <= rx_overrun;
              if (fcnt < LEN_W'(5)) flg.bc <= 1'b0;
            end
            if (need_wr) begin
              eof_q <= rx_eof;
              state <= ST_DATA;
            end else if (rx_eof) state <= ST_WB;
          end
        end
        ST_DATA: begin
          if (mem_ack) begin
            buf_wr <= buf_wr + AW'(4);
            state  <= eof_q ? ST_WB : ST_RECV;
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            cur_ptr  <= wrap_q ? ring_base : cur_ptr + AW'(8);
            flg.miss <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R13: a pending request keeps its address and direction
  a_r13_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R13: no byte is taken while the bus is busy
  a_r13_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> !mem_req);
  // R3: a descriptor held by software stops the walk
  a_r3_stop_on_owned: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DESC0 && mem_ack && !mem_rdata[16+SB_EMPTY] && !act_set)
      |=> (!active && !mem_req));
  // R6: non-wrap descriptor advances by eight bytes
  a_r6_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB && mem_ack && !wrap_q) |=> (cur_ptr == $past(cur_ptr) + AW'(8)));
  // R7: stored length never passes the buffer size
  a_r7_len_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WB) |-> (scnt <= buf_size));
endmodule

// File: rtl/rxbd_engine.sv
module rxbd_engine
  import rxbd_pkg::*;
#(
  parameter int AW      = 32,
  parameter int LEN_W   = 16,
  parameter int CNT_W   = 16,
  parameter int RA_W    = 3,
  parameter int BSZ_RST = 1536,
  parameter int MFL_RST = 1522
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_eof,
  input  logic             rx_crc_err,
  input  logic             rx_align_err,
  input  logic             rx_overrun,
  output logic             rx_ready,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             irq,
  output logic [CNT_W-1:0] drop_cnt
);
  logic             act_set, base_load, evt_set;
  logic [AW-1:0]    ring_base;
  logic [LEN_W-1:0] buf_size;
  logic [MFL_W-1:0] max_fl;

  rxbd_regs #(
    .AW(AW), .LEN_W(LEN_W), .RA_W(RA_W), .BSZ_RST(BSZ_RST), .MFL_RST(MFL_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt_set(evt_set), .act_set(act_set),
    .base_load(base_load), .ring_base(ring_base), .buf_size(buf_size),
    .max_fl(max_fl), .irq(irq)
  );

  rxbd_walker #(.AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst(rst), .act_set(act_set), .base_load(base_load),
    .ring_base(ring_base), .buf_size(buf_size), .max_fl(max_fl),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_eof(rx_eof),
    .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err),
    .rx_overrun(rx_overrun), .rx_ready(rx_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .evt_set(evt_set), .drop_cnt(drop_cnt)
  );
endmodule

// File: tb/rxbd_engine_test.sv
module rxbd_engine_test;
  localparam int BSZ = 16;
  localparam int MFL = 20;
  localparam logic [31:0] SENT = 32'h5EA5_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        rx_valid = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_crc_err = 1'b0, rx_align_err = 1'b0, rx_overrun = 1'b0;
  logic        rx_ready, mem_req, mem_we, mem_ack = 1'b0, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [15:0] drop_cnt;

  logic [31:0] mem [0:255];
  int n_chk = 0, n_bad = 0, acc_cnt = 0, fidx = 0;
  bit done = 1'b0;

  rxbd_engine uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_eof(rx_eof), .rx_crc_err(rx_crc_err), .rx_align_err(rx_align_err),
    .rx_overrun(rx_overrun), .rx_ready(rx_ready), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq), .drop_cnt(drop_cnt)
  );

  // memory model: acknowledges one cycle after the request appears
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[9:2]];
    end
    if (mem_req && mem_ack) acc_cnt++;
    mem_ack <= mem_req && !mem_ack && !rst;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(int a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [7:0] fbyte(int kind, int len, int i);
    if (kind == 1 && i < 6) return 8'hFF;
    if (kind == 2 && i == 0) return 8'h01;
    if (kind == 3) return 8'hFF;
    return 8'(len * 5 + i * 3) & 8'hFE;
  endfunction

  task automatic send_frame(int kind, int len, bit crc, bit aln, bit ovr);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = fbyte(kind, len, i); rx_eof = (i == len - 1);
      rx_crc_err = crc; rx_align_err = aln; rx_overrun = ovr;
      while (!rx_ready) @(negedge clk);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_eof = 1'b0;
    rx_crc_err = 1'b0; rx_align_err = 1'b0; rx_overrun = 1'b0;
  endtask

  task automatic arm_desc(int d);
    mem[16 + 2*d] = {(d == 3) ? 16'hA000 : 16'h8000, 16'h0000};
    mem[17 + 2*d] = 32'h100 + 32'(32 * d);
    for (int w = 0; w < 8; w++) mem[64 + 8*d + w] = SENT | 32'(w);
  endtask

  task automatic run_frame(string tag, int kind, int len, bit crc, bit aln,
                           bit ovr, bit miss, bit irq_exp);
    int d, stored, t;
    logic [15:0] st;
    logic [31:0] ew;
    bit bc, mc;
    d = fidx % 4;
    send_frame(kind, len, crc, aln, ovr);
    t = 0;
    while (mem[16 + 2*d][31] && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    stored = (len < BSZ) ? len : BSZ;
    bc = (len >= 6);
    for (int i = 0; i < 6; i++) if (i < len && fbyte(kind, len, i) != 8'hFF) bc = 1'b0;
    mc = fbyte(kind, len, 0)[0] && !bc;
    st = 16'h0800;
    if (d == 3)     st[13] = 1'b1;
    if (miss)       st[8]  = 1'b1;
    if (bc)         st[7]  = 1'b1;
    if (mc)         st[6]  = 1'b1;
    if (len > MFL)  st[5]  = 1'b1;
    if (aln)        st[4]  = 1'b1;
    if (crc)        st[2]  = 1'b1;
    if (ovr)        st[1]  = 1'b1;
    if (len > BSZ)  st[0]  = 1'b1;
    check($sformatf("R5 R7 R8 R9 R10 R11 %s len=%0d writeback", tag, len),
          mem[16 + 2*d], {st, 16'(stored)});
    for (int w = 0; w < 5; w++) begin
      if (4*w >= stored) ew = SENT | 32'(w);
      else begin
        ew = '0;
        for (int l = 0; l < 4; l++)
          if (4*w + l < stored) ew[8*l +: 8] = fbyte(kind, len, 4*w + l);
      end
      check($sformatf("R4 R6 R7 %s len=%0d desc=%0d word%0d", tag, len, d, w),
            mem[64 + 8*d + w], ew);
    end
    check($sformatf("R12 %s len=%0d irq", tag, len), 32'(irq), 32'(irq_exp));
    if (irq_exp) wr_reg(4, 32'h0200_0000);
    arm_desc(d);
    fidx++;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 mem_req after reset", 32'(mem_req), 0);
    check("R1 irq after reset", 32'(irq), 0);
    check("R1 drop_cnt after reset", 32'(drop_cnt), 0);
    check("R1 rx_ready after reset", 32'(rx_ready), 1);

    wr_reg(1, 32'h0000_0047);          // base 0x40, low bits forced off
    wr_reg(2, 32'h0000_001F);          // buffer size 16 after masking
    wr_reg(3, 32'(MFL) << 16);
    wr_reg(5, 32'h0200_0000);
    // R2: trigger without bit 24 does nothing
    wr_reg(0, 32'h00FF_FFFF);
    repeat (20) @(negedge clk);
    check("R2 no fetch without trigger bit", 32'(acc_cnt), 0);
    // R3: descriptor 0 is software-owned (all zero) -> single read, then stop
    wr_reg(0, 32'h0100_0000);
    repeat (20) @(negedge clk);
    check("R2 R3 one descriptor read then stop", 32'(acc_cnt), 1);
    check("R3 engine stopped accepts input", 32'(rx_ready), 1);
    // R11: frame while stopped is discarded
    send_frame(0, 5, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 drop counted", 32'(drop_cnt), 1);
    check("R11 no memory access for dropped frame", 32'(acc_cnt), 1);

    for (int d = 0; d < 4; d++) arm_desc(d);
    wr_reg(0, 32'h0100_0000);
    for (int len = 1; len <= 40; len++)
      run_frame("sweep", 0, len, 1'b0, 1'b0, 1'b0, len == 1, 1'b1);
    check("R11 drop count unchanged", 32'(drop_cnt), 1);

    run_frame("bcast", 1, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame("mcast", 2, 8, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame("short-ff", 3, 4, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame("bcast-long", 1, 24, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame("crc", 0, 10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    run_frame("align-ovr", 0, 12, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);

    // R12: masked event stays pending, then unmasks and clears
    wr_reg(5, 32'h0000_0000);
    run_frame("masked", 0, 9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    wr_reg(5, 32'h0200_0000);
    repeat (2) @(negedge clk);
    check("R12 pending event raises irq when unmasked", 32'(irq), 1);
    wr_reg(4, 32'h0100_0000);
    repeat (3) @(negedge clk);
    check("R12 write of other bit keeps event", 32'(irq), 1);
    wr_reg(4, 32'h0200_0000);
    repeat (3) @(negedge clk);
    check("R12 write-one clears event", 32'(irq), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R13 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule